// File: doc/BRIEF.md
# Converter Sample Output Formatter

This block sits between an 8-bit sample source and a set of output ports. It accepts one sample per clock, optionally recodes it from straight binary into Gray code, and presents it either on a single high port (one-to-one mode) or spread over a low and a high port that each update at half the sample rate (split mode). A data-ready strobe goes with the data. It toggles once for every output update, so a receiver can latch data on both its rising and falling edges.

A synchronisation input halts the outputs and restarts them in a known phase. It must be pulsed after any change of mode or coding. While it is high, the ports are cleared and no sample is taken. After it falls, acceptance resumes after one clock, or after two clocks when the extra-delay option is set. The wider window makes the pulse easier to place. The first sample taken after a restart always lands on the low port in split mode. The configuration inputs are static and may only change around a synchronisation pulse.

The input is a valid/ready stream without real back-pressure. The source cannot be stalled, so a sample offered while `in_ready` is low is dropped, not held. `in_ready` is low only during a synchronisation pulse and the restart delay that follows it. A clock with `in_valid` low is a gap: nothing is taken and the outputs and strobe hold.

Top module: `sample_fmt_top`

## Requirements
- R1: After reset, `out_lo` and `out_hi` are zero, `out_strobe` is low and `in_ready` is high.
- R2: In one-to-one mode (`cfg_split`=0), a sample accepted at clock edge k appears on `out_hi` after edge k+1, and `out_lo` stays zero.
- R3: With `cfg_gray`=1, each port value is g = b ^ (b >> 1) of the accepted 8-bit sample b. With `cfg_gray`=0, it is b unchanged.
- R4: In split mode (`cfg_split`=1), the first sample accepted after a restart goes to `out_lo` and the next one to `out_hi`, and so on in pairs. Both ports of a pair update together after edge k+2, where k is the edge that accepted the first sample of the pair.
- R5: `out_strobe` inverts at every output update: once per sample in one-to-one mode and once per pair in split mode. Its first update after a restart drives it high.
- R6: While `sync` is high, `in_ready` is low. From the edge after `sync` is seen high, both ports read zero and `out_strobe` is low. Any partly formed pair and any sample in flight are discarded.
- R7: With `cfg_xdelay`=0, `in_ready` rises at the first clock edge that samples `sync` low. With `cfg_xdelay`=1, it rises at the second such edge.
- R8: A sample is accepted only on an edge where `in_valid` and `in_ready` are both high. Samples offered while `in_ready` is low never reach a port. A clock with `in_valid` low leaves both ports and `out_strobe` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Sample will be accepted on this edge |
| in_data | input | 8 | Binary sample code |
| cfg_split | input | 1 | 0: one-to-one on high port; 1: split low/high |
| cfg_gray | input | 1 | 1: Gray-code the output values |
| cfg_xdelay | input | 1 | 1: one more clock of restart delay after sync |
| sync | input | 1 | Halt outputs and restart in known phase |
| out_lo | output | 8 | Low port (split mode only) |
| out_hi | output | 8 | High port |
| out_strobe | output | 1 | Toggling data-ready strobe |

## Verification
The bench builds the block with an 8-bit sample width and with the Gray recoding stage generated, so the binary and Gray paths can both be reached from `cfg_gray`. These defaults expose the all-ones and zero codes at the edge of the sample range. They also allow split mode to be run across the extra-delay restart, with samples offered during that delay that must be dropped. The one-clock restart path, gaps in the stream and a sync pulse over live data are each driven as separate scenarios.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} phase_e;
  localparam int unsigned RESTART_W = 2;
endpackage

// File: rtl/sfmt_sync_ctl.sv
module sfmt_sync_ctl
  import sfmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync,
  input  logic cfg_xdelay,
  output logic in_ready,
  output logic flush
);
  logic [RESTART_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      wait_cnt <= '0;
    else if (sync)
      wait_cnt <= cfg_xdelay ? RESTART_W'(2) : RESTART_W'(1);
    else if (wait_cnt != '0)
      wait_cnt <= wait_cnt - 1'b1;
  end

  assign in_ready = !sync && (wait_cnt == '0);
  assign flush    = sync;

  // R7: no acceptance in the clock right after a sync cycle
  a_r7_gap_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync) |-> !in_ready);
  // R7: extra delay holds ready low one more clock
  a_r7_extra_delay: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sync, 2) && !$past(sync) && $past(cfg_xdelay, 2)) |-> !in_ready);
  // R7: two quiet sync edges always restore ready
  a_r7_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !$past(sync) && !$past(sync, 2)) |-> in_ready);
endmodule

// File: rtl/sfmt_coder.sv
module sfmt_coder #(
  parameter int unsigned W       = 8,
  parameter bit          GRAY_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         take,
  input  logic [W-1:0] din,
  input  logic         cfg_gray,
  output logic         s_valid,
  output logic [W-1:0] s_data
);
  logic [W-1:0] coded;

  generate
    if (GRAY_EN) begin : g_gray
      assign coded = cfg_gray ? (din ^ (din >> 1)) : din;
    end else begin : g_bin
      assign coded = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      s_valid <= 1'b0;
      s_data  <= '0;
    end else begin
      s_valid <= take;
      if (take) s_data <= coded;
    end
  end

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // R8: an accepted sample always enters the pipeline
  a_r8_take_staged: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !flush) |=> s_valid);
  generate
    if (GRAY_EN) begin : g_chk
      // R3: staged Gray value decodes back to the accepted sample
      a_r3_gray_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && $past(cfg_gray)) |-> (gray_to_bin(s_data) == $past(din)));
    end
  endgenerate
endmodule

// File: rtl/sfmt_demux.sv
module sfmt_demux
  import sfmt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         cfg_split,
  input  logic         s_valid,
  input  logic [W-1:0] s_data,
  output logic [W-1:0] out_lo,
  output logic [W-1:0] out_hi,
  output logic         out_strobe
);
  phase_e       phase;
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      phase      <= PH_LO;
      held       <= '0;
      out_lo     <= '0;
      out_hi     <= '0;
      out_strobe <= 1'b0;
    end else if (s_valid) begin
      if (!cfg_split) begin
        out_hi     <= s_data;
        out_strobe <= ~out_strobe;
      end else if (phase == PH_LO) begin
        held  <= s_data;
        phase <= PH_HI;
      end else begin
        out_lo     <= held;
        out_hi     <= s_data;
        out_strobe <= ~out_strobe;
        phase      <= PH_LO;
      end
    end
  end

  // R6: a sync cycle clears the ports and the strobe
  a_r6_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (out_lo == '0 && out_hi == '0 && !out_strobe));
  // R5: in one-to-one mode every staged sample flips the strobe
  a_r5_strobe_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !flush && !cfg_split) |=> (out_strobe != $past(out_strobe)));
  // R8: gaps leave the ports and strobe alone
  a_r8_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !flush) |=> ($stable(out_lo) && $stable(out_hi) && $stable(out_strobe)));
  // R4: the low half of a pair never changes the strobe
  a_r4_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !flush && cfg_split && phase == PH_LO) |=> $stable(out_strobe));
endmodule

// File: rtl/sample_fmt_top.sv
module sample_fmt_top #(
  parameter int unsigned W       = 8,
  parameter bit          GRAY_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         cfg_split,
  input  logic         cfg_gray,
  input  logic         cfg_xdelay,
  input  logic         sync,
  output logic [W-1:0] out_lo,
  output logic [W-1:0] out_hi,
  output logic         out_strobe
);
  logic         flush;
  logic         take;
  logic         s_valid;
  logic [W-1:0] s_data;

  sfmt_sync_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync       (sync),
    .cfg_xdelay (cfg_xdelay),
    .in_ready   (in_ready),
    .flush      (flush)
  );

  assign take = in_valid && in_ready;

  sfmt_coder #(.W(W), .GRAY_EN(GRAY_EN)) u_coder (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .take     (take),
    .din      (in_data),
    .cfg_gray (cfg_gray),
    .s_valid  (s_valid),
    .s_data   (s_data)
  );

  sfmt_demux #(.W(W)) u_demux (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .cfg_split  (cfg_split),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .out_lo     (out_lo),
    .out_hi     (out_hi),
    .out_strobe (out_strobe)
  );

  // R6: sync blocks acceptance
  a_r6_no_take_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !take);
endmodule

// File: tb/sample_fmt_top_test.sv
module sample_fmt_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       cfg_split = 1'b0;
  logic       cfg_gray = 1'b0;
  logic       cfg_xdelay = 1'b0;
  logic       sync = 1'b0;
  logic [7:0] out_lo;
  logic [7:0] out_hi;
  logic       out_strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sample_fmt_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_split(cfg_split), .cfg_gray(cfg_gray),
    .cfg_xdelay(cfg_xdelay), .sync(sync), .out_lo(out_lo), .out_hi(out_hi),
    .out_strobe(out_strobe)
  );

  function automatic logic [7:0] smp(input int n);
    if (n == 3) return 8'hFF;
    if (n == 4) return 8'h00;
    if (n == 5) return 8'h80;
    return 8'((n * 53 + 17) & 255);
  endfunction

  function automatic logic [7:0] enc(input logic [7:0] b, input logic g);
    return g ? (b ^ (b >> 1)) : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pulses sync, checks the halt and the restart delay; leaves the bench
  // on a falling edge where in_ready is high.
  task automatic do_sync(input logic xd);
    @(negedge clk);
    cfg_xdelay = xd;
    sync = 1'b1;
    in_valid = 1'b1;
    in_data = 8'h5A;
    #1 chk(!in_ready, "R6 ready low during sync", in_ready, 0);
    @(negedge clk);
    chk(out_hi == 0 && out_lo == 0, "R6 ports zero in sync", {out_hi, out_lo}, 0);
    chk(out_strobe == 1'b0, "R6 strobe low in sync", out_strobe, 0);
    sync = 1'b0;
    in_data = 8'hA5;
    #1 chk(!in_ready, "R7 ready low before first quiet edge", in_ready, 0);
    @(negedge clk);
    if (xd) begin
      chk(!in_ready, "R7 extra delay keeps ready low", in_ready, 0);
      in_data = 8'h3C;
      @(negedge clk);
    end
    chk(in_ready, "R7 ready back after restart", in_ready, 1);
  endtask

  task automatic t_reset;
    chk(out_hi == 0 && out_lo == 0, "R1 ports zero", {out_hi, out_lo}, 0);
    chk(out_strobe == 1'b0, "R1 strobe low", out_strobe, 0);
    chk(in_ready == 1'b1, "R1 ready high", in_ready, 1);
  endtask

  task automatic t_one_to_one(input logic g);
    cfg_split = 1'b0;
    cfg_gray = g;
    do_sync(1'b0);
    for (int n = 0; n < 14; n++) begin
      if (n >= 2) begin
        chk(out_hi == enc(smp(n - 2), g), g ? "R3 gray on high port" : "R2 binary on high port",
            out_hi, enc(smp(n - 2), g));
        chk(out_lo == 0, "R2 low port idle", out_lo, 0);
        chk(out_strobe == ((n - 2) % 2 == 0), "R5 strobe per sample", out_strobe, ((n - 2) % 2 == 0));
      end
      in_valid = 1'b1;
      in_data = smp(n);
      @(negedge clk);
    end
  endtask

  task automatic t_split;
    cfg_split = 1'b1;
    cfg_gray = 1'b0;
    do_sync(1'b1);
    for (int n = 0; n < 16; n++) begin
      if (n == 2) begin
        chk(out_hi == 0 && out_lo == 0, "R4 no pair yet, R8 dropped samples absent",
            {out_hi, out_lo}, 0);
      end else if (n >= 3) begin
        int j = (n - 3) / 2;
        chk(out_lo == smp(2 * j), "R4 low port first of pair", out_lo, smp(2 * j));
        chk(out_hi == smp(2 * j + 1), "R4 high port second of pair", out_hi, smp(2 * j + 1));
        chk(out_strobe == (j % 2 == 0), "R5 strobe per pair", out_strobe, (j % 2 == 0));
      end
      in_valid = 1'b1;
      in_data = smp(n);
      @(negedge clk);
    end
  endtask

  task automatic t_gap;
    cfg_split = 1'b0;
    cfg_gray = 1'b0;
    do_sync(1'b0);
    in_valid = 1'b1;
    in_data = 8'hC3;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 8'h11;
    @(negedge clk);
    chk(out_hi == 8'hC3 && out_strobe, "R8 sample before gap", out_hi, 8'hC3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_hi == 8'hC3, "R8 gap holds port", out_hi, 8'hC3);
      chk(out_strobe == 1'b1, "R8 gap holds strobe", out_strobe, 1);
    end
  endtask

  task automatic t_sync_live;
    cfg_split = 1'b0;
    cfg_gray = 1'b1;
    do_sync(1'b0);
    in_valid = 1'b1;
    in_data = 8'hF0;
    @(negedge clk);
    sync = 1'b1;
    @(negedge clk);
    chk(out_hi == 0 && out_strobe == 0, "R6 in-flight sample discarded", out_hi, 0);
    sync = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(out_hi == 0, "R6 nothing released after sync", out_hi, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_to_one(1'b0);
    t_one_to_one(1'b1);
    t_split();
    t_gap();
    t_sync_live();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule